// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives a clock-out pin from the main reference clock. The division ratio is 1, 2, 4 or 8 and a 2-bit code selects it. After reset the pin stays low until an internal start-up timer, counted in main-clock cycles, runs out. After that the pin toggles at the selected ratio. An active-low enable bit can stop the output. A new ratio or enable setting is adopted only where the current output period ends on its falling edge, so the pin never produces a shortened pulse.

A second output carries a slow sleep clock. A 2-bit code selects its source from two asynchronous inputs: an external crystal signal or an internal ring oscillator signal. The source is synchronised into the main clock domain, and its rising edges are counted. The output divides the source by 2^n, where n is a 5-bit exponent. If no valid source is selected, the output is held low. Every divider is a counter in the main clock domain. The only clock-like signals are the final output registers and the gate used for the divide-by-1 case.

Top module: `clkout_gen`

## Requirements
- R1: With the output running, ratio code 2'b00 gives main/8, 2'b01 gives main/4, 2'b10 gives main/2 and 2'b11 gives main/1. Every output is 50 % duty, each high and each low phase lasting ratio/2 main cycles, or half a cycle for main/1.
- R2: The enable input is active low. While `outDisable` is 1 the clock-out pin stays low; while it is 0 the pin toggles at the selected ratio.
- R3: After reset is released, the clock-out pin stays low for at least `STARTUP_CYC` main-clock cycles. Once the start-up timer expires, the pin begins toggling within a few further periods.
- R4: With the ratio code left at 2'b00 after start-up, the output is main/8.
- R5: A change of ratio code or enable takes effect only at the end of a full output period. Across any change, no high or low phase is shorter than the shorter phase of the old and new ratios.
- R6: The sleep clock output equals the selected source divided by 2^n, where n is `slpExp`. With n = 0 the output follows the synchronised source.
- R7: The sleep source is chosen by `slpSrc`: 2'b01 selects `slpXtal` and 2'b10 selects `slpRing`. The codes 2'b00 and 2'b11 drive the sleep output low.
- R8: While reset is asserted, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | 2 | Output ratio code |
| outDisable | input | 1 | Active-low enable: 1 stops the output |
| slpXtal | input | 1 | External crystal sleep source, asynchronous |
| slpRing | input | 1 | Ring oscillator sleep source, asynchronous |
| slpSrc | input | 2 | Sleep source select |
| slpExp | input | 5 | Sleep divider exponent n (divide by 2^n) |
| clkOut | output | 1 | Divided clock-out pin |
| slpClkOut | output | 1 | Divided sleep clock |

## Verification
On every cycle, the assertions check several properties. The output registers stay low through the start-up window and while the output is stopped. The ratio and enable settings move only at period boundaries. The divide-by-1 gate and the divided register are never high together. The sleep output is low under an invalid source code. Only the bench scenarios can show the measured phase lengths for each ratio, the absence of runt phases across every ordered pair of ratio changes, and the sleep frequency relative to each source across exponents.

// File: rtl/clkout_gen_pkg.sv
package clkout_gen_pkg;

  // largest main-clock division ratio; codes count down from it by powers of two
  localparam int MAX_RATIO = 8;

  typedef enum logic [1:0] {
    DIV8 = 2'b00,
    DIV4 = 2'b01,
    DIV2 = 2'b10,
    DIV1 = 2'b11
  } divsel_e;

  typedef enum logic [1:0] {
    SLP_NONE = 2'b00,
    SLP_XTAL = 2'b01,
    SLP_RING = 2'b10,
    SLP_RSVD = 2'b11
  } slpsrc_e;

  // control to datapath strobes
  typedef struct packed {
    logic    run;
    divsel_e sel;
  } ctl_strb_t;

endpackage

// File: rtl/clkout_gen_ctrl.sv
module clkout_gen_ctrl
  import clkout_gen_pkg::*;
#(
  parameter int STARTUP_CYC = 1024
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] divSel,
  input  logic      outDisable,
  input  logic      periodEnd,
  output ctl_strb_t strb
);

  localparam int TMR_W = $clog2(STARTUP_CYC + 2);

  logic [TMR_W-1:0] tmrQ;
  logic             startDone;
  ctl_strb_t        cfgQ;

  assign startDone = (tmrQ == TMR_W'(STARTUP_CYC));

  // start-up timer: counts main cycles once after reset, then holds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrQ <= '0;
    end else if (!startDone) begin
      tmrQ <= tmrQ + 1'b1;
    end
  end

  // settings are adopted only where the datapath reports a period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.run <= 1'b0;
      cfgQ.sel <= DIV8;
    end else if (periodEnd) begin
      cfgQ.run <= startDone & ~outDisable;
      cfgQ.sel <= divsel_e'(divSel);
    end
  end

  assign strb = cfgQ;

endmodule

// File: rtl/clkout_gen_dp.sv
module clkout_gen_dp
  import clkout_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ctl_strb_t strb,
  output logic      periodEnd,
  output logic      divQ,
  output logic      gateQ,
  output logic      clkOut
);

  localparam int CNT_W = (MAX_RATIO > 4) ? $clog2(MAX_RATIO / 2) : 1;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] halfLast;
  logic             bypass;

  // last count value of one half period for the active ratio
  always_comb begin
    halfLast = '0;
    if (strb.sel != DIV1) begin
      halfLast = CNT_W'(((MAX_RATIO >> strb.sel) / 2) - 1);
    end
  end

  assign bypass    = !strb.run || (strb.sel == DIV1);
  assign periodEnd = bypass || (divQ && (cntQ == halfLast));

  // divided output register for ratios of two and above
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      divQ <= 1'b0;
    end else if (bypass) begin
      cntQ <= '0;
      divQ <= 1'b0;
    end else if (cntQ == halfLast) begin
      cntQ <= '0;
      divQ <= ~divQ;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // divide-by-one gate, updated while the clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ <= 1'b0;
    end else begin
      gateQ <= strb.run && (strb.sel == DIV1);
    end
  end

  assign clkOut = (clk & gateQ) | divQ;

endmodule

// File: rtl/clkout_gen_slp.sv
module clkout_gen_slp
  import clkout_gen_pkg::*;
#(
  parameter int EXP_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slpXtal,
  input  logic             slpRing,
  input  logic [1:0]       slpSrc,
  input  logic [EXP_W-1:0] slpExp,
  output logic             slpClkOut
);

  localparam int CNT_W = (1 << EXP_W) - 1;

  logic                 srcRaw;
  logic                 srcValid;
  logic [SYNC_STAGES:0] syncQ;
  logic                 srcLvl;
  logic                 srcRise;
  logic [CNT_W-1:0]     cntQ;
  logic [CNT_W-1:0]     cntNext;
  logic                 divBit;
  logic                 outQ;

  always_comb begin
    unique case (slpsrc_e'(slpSrc))
      SLP_XTAL: srcRaw = slpXtal;
      SLP_RING: srcRaw = slpRing;
      default:  srcRaw = 1'b0;
    endcase
  end

  assign srcValid = (slpSrc == SLP_XTAL) || (slpSrc == SLP_RING);

  // synchroniser chain plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-1:0], srcRaw};
    end
  end

  assign srcLvl  = syncQ[SYNC_STAGES-1];
  assign srcRise = srcLvl & ~syncQ[SYNC_STAGES];
  assign cntNext = srcRise ? cntQ + 1'b1 : cntQ;
  assign divBit  = (slpExp == '0) ? srcLvl : cntNext[slpExp - 1'b1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      outQ <= 1'b0;
    end else if (!srcValid) begin
      cntQ <= '0;
      outQ <= 1'b0;
    end else begin
      cntQ <= cntNext;
      outQ <= divBit;
    end
  end

  assign slpClkOut = outQ;

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_gen_pkg::*;
#(
  parameter int STARTUP_CYC = 1024,
  parameter int SLP_EXP_W   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           divSel,
  input  logic                 outDisable,
  input  logic                 slpXtal,
  input  logic                 slpRing,
  input  logic [1:0]           slpSrc,
  input  logic [SLP_EXP_W-1:0] slpExp,
  output logic                 clkOut,
  output logic                 slpClkOut
);

  ctl_strb_t strb;
  logic      periodEnd;
  logic      divQ;
  logic      gateQ;

  clkout_gen_ctrl #(
    .STARTUP_CYC(STARTUP_CYC)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .divSel    (divSel),
    .outDisable(outDisable),
    .periodEnd (periodEnd),
    .strb      (strb)
  );

  clkout_gen_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .periodEnd(periodEnd),
    .divQ     (divQ),
    .gateQ    (gateQ),
    .clkOut   (clkOut)
  );

  clkout_gen_slp #(
    .EXP_W      (SLP_EXP_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) slp_i (
    .clk      (clk),
    .rstN     (rstN),
    .slpXtal  (slpXtal),
    .slpRing  (slpRing),
    .slpSrc   (slpSrc),
    .slpExp   (slpExp),
    .slpClkOut(slpClkOut)
  );

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk
  import clkout_gen_pkg::*;
#(
  parameter int STARTUP_CYC = 1024
) (
  input logic      clk,
  input logic      rstN,
  input ctl_strb_t strb,
  input logic      periodEnd,
  input logic      divQ,
  input logic      gateQ,
  input logic [1:0] slpSrc,
  input logic      slpClkOut
);

  logic [31:0] cycQ;

  // independent count of cycles since reset, saturating at the window length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycQ <= '0;
    end else if (cycQ < 32'(STARTUP_CYC)) begin
      cycQ <= cycQ + 1'b1;
    end
  end

  a_r3_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (cycQ < 32'(STARTUP_CYC)) |-> (!divQ && !gateQ));

  a_r2_off_low: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> !divQ);

  a_r5_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd |=> $stable(strb));

  a_r1_one_source: assert property (@(posedge clk) disable iff (!rstN)
    !(divQ && gateQ));

  a_r1_div_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divQ) |-> (strb.run && strb.sel != DIV1));

  a_r7_sleep_none_low: assert property (@(posedge clk) disable iff (!rstN)
    (slpSrc == 2'b00 || slpSrc == 2'b11) |=> !slpClkOut);

endmodule

bind clkout_gen clkout_gen_chk #(
  .STARTUP_CYC(STARTUP_CYC)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .periodEnd(periodEnd),
  .divQ     (divQ),
  .gateQ    (gateQ),
  .slpSrc   (slpSrc),
  .slpClkOut(slpClkOut)
);

// File: tb/clkout_gen_tb_top.sv
module clkout_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STARTUP    = 16;
  localparam int NSMP_MAX   = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] divSel = 2'b00;
  logic       outDisable = 1'b0;
  logic       slpXtal = 1'b0;
  logic       slpRing = 1'b0;
  logic [1:0] slpSrc = 2'b00;
  logic [4:0] slpExp = 5'd0;
  logic       clkOut;
  logic       slpClkOut;

  int nChk = 0;
  int nFail = 0;
  logic smp [NSMP_MAX];

  always #(CLK_PERIOD / 2) clk = ~clk;

  // asynchronous-looking slow sources: crystal period 6 cycles, ring period 4 cycles
  int xCnt = 0;
  int rCnt = 0;
  always @(negedge clk) begin
    xCnt = xCnt + 1;
    rCnt = rCnt + 1;
    if (xCnt == 3) begin xCnt = 0; slpXtal = ~slpXtal; end
    if (rCnt == 2) begin rCnt = 0; slpRing = ~slpRing; end
  end

  clkout_gen #(.STARTUP_CYC(STARTUP)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .divSel    (divSel),
    .outDisable(outDisable),
    .slpXtal   (slpXtal),
    .slpRing   (slpRing),
    .slpSrc    (slpSrc),
    .slpExp    (slpExp),
    .clkOut    (clkOut),
    .slpClkOut (slpClkOut)
  );

  function automatic int ratioOf(input logic [1:0] code);
    return 8 >> code;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  // two samples per cycle: clock high phase and clock low phase;
  // optionally applies a new setting after cycle chgAt's high sample
  task automatic record(input int nCyc, input int chgAt,
                        input logic [1:0] newSel, input logic newDis);
    for (int c = 0; c < nCyc; c++) begin
      @(posedge clk); #2;
      smp[2*c] = clkOut;
      if (c == chgAt) begin
        divSel = newSel;
        outDisable = newDis;
      end
      @(negedge clk); #2;
      smp[2*c+1] = clkOut;
    end
  endtask

  // interior phase lengths (in half-cycle samples); the first and last are partial
  task automatic chkRuns(input int nSmp, input int lenExp, input bit exact, input string req);
    int runLen = 1;
    int runs = 0;
    int bad = 0;
    int badLen = lenExp;
    for (int i = 1; i < nSmp; i++) begin
      if (smp[i] == smp[i-1]) begin
        runLen++;
      end else begin
        if (runs > 0) begin
          if (exact ? (runLen != lenExp) : (runLen < lenExp)) begin
            bad++;
            badLen = runLen;
          end
        end
        runs++;
        runLen = 1;
      end
    end
    check(bad == 0 && runs >= 3, req, (runs < 3) ? runs : badLen, lenExp);
  endtask

  task automatic chkSleep(input logic [1:0] src, input logic [4:0] ex, input string req);
    int srcRises = 0;
    int outRises = 0;
    int outOnes = 0;
    int expRises;
    logic prevSrc;
    logic prevOut;
    logic curSrc;
    slpSrc = src;
    slpExp = ex;
    waitCyc(40);
    prevSrc = (src == 2'b01) ? slpXtal : slpRing;
    prevOut = slpClkOut;
    for (int c = 0; c < 256; c++) begin
      @(posedge clk); #2;
      curSrc = (src == 2'b01) ? slpXtal : slpRing;
      if (curSrc && !prevSrc) srcRises++;
      if (slpClkOut && !prevOut) outRises++;
      if (slpClkOut) outOnes++;
      prevSrc = curSrc;
      prevOut = slpClkOut;
    end
    if (src == 2'b01 || src == 2'b10) begin
      expRises = srcRises >> ex;
      check(outRises >= expRises - 1 && outRises <= expRises + 1, req, outRises, expRises);
    end else begin
      check(outOnes == 0, req, outOnes, 0);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin : stim
    int ones;
    bit seenHigh;
    // R8: outputs low during reset
    slpSrc = 2'b10;
    for (int c = 0; c < 6; c++) begin
      @(posedge clk); #2;
      check(clkOut == 1'b0, "R8 clkOut in reset", clkOut, 0);
      check(slpClkOut == 1'b0, "R8 slpClkOut in reset", slpClkOut, 0);
    end
    slpSrc = 2'b00;
    rstN = 1'b1;

    // R3: held low through the start-up window, then starts
    ones = 0;
    for (int c = 0; c < STARTUP; c++) begin
      @(posedge clk); #2;
      if (clkOut) ones++;
      @(negedge clk); #2;
      if (clkOut) ones++;
    end
    check(ones == 0, "R3 low during start-up", ones, 0);
    seenHigh = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(posedge clk); #2;
      if (clkOut) seenHigh = 1'b1;
    end
    check(seenHigh, "R3 toggling after start-up", seenHigh, 1);

    // R4: default code gives divide-by-8
    record(64, -1, 2'b00, 1'b0);
    chkRuns(128, 8, 1'b1, "R4 default divide by 8");

    // R1: every ratio code in steady state
    for (int s = 0; s < 4; s++) begin
      divSel = 2'(s);
      waitCyc(20);
      record(64, -1, 2'(s), 1'b0);
      chkRuns(128, ratioOf(2'(s)), 1'b1, "R1 steady ratio");
    end

    // R5: every ordered pair of ratio changes, mid-period, no runt phase
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          divSel = 2'(a);
          waitCyc(20 + a + b);
          record(64, 31, 2'(b), 1'b0);
          chkRuns(128, (ratioOf(2'(a)) < ratioOf(2'(b))) ? ratioOf(2'(a)) : ratioOf(2'(b)),
                  1'b0, "R5 no runt across ratio change");
          waitCyc(10);
          record(40, -1, 2'(b), 1'b0);
          chkRuns(80, ratioOf(2'(b)), 1'b1, "R5 new ratio adopted");
        end
      end
    end

    // R2: active-low enable; disabling mid-period keeps the last phase whole
    divSel = 2'b00;
    waitCyc(20);
    record(40, 21, 2'b00, 1'b1);
    chkRuns(80, 8, 1'b0, "R2 R5 full phase before stop");
    waitCyc(10);
    record(64, -1, 2'b00, 1'b1);
    ones = 0;
    for (int i = 0; i < 128; i++) if (smp[i]) ones++;
    check(ones == 0, "R2 disabled output low", ones, 0);
    for (int s = 0; s < 4; s++) begin
      divSel = 2'(s);
      waitCyc(10);
      record(32, -1, 2'(s), 1'b1);
      ones = 0;
      for (int i = 0; i < 64; i++) if (smp[i]) ones++;
      check(ones == 0, "R2 disabled low at each ratio", ones, 0);
    end
    outDisable = 1'b0;
    divSel = 2'b01;
    waitCyc(20);
    record(64, -1, 2'b01, 1'b0);
    chkRuns(128, 4, 1'b1, "R2 re-enabled output runs");

    // R6 R7: sleep divider per source and exponent
    for (int e = 0; e < 5; e++) begin
      chkSleep(2'b01, 5'(e), "R6 R7 crystal source divide");
      chkSleep(2'b10, 5'(e), "R6 R7 ring source divide");
    end
    chkSleep(2'b10, 5'd31, "R6 largest exponent");
    chkSleep(2'b00, 5'd0, "R7 none source low");
    chkSleep(2'b11, 5'd0, "R7 reserved source low");
    chkSleep(2'b11, 5'd2, "R7 reserved source low, exponent 2");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule